// File: doc/BRIEF.md
# EDO DRAM Access Timing Sequencer

This block runs one read or one write cycle on an EDO DRAM. The memory controller presents a request with a direction, a row and a column. The sequencer then drives the active-low RAS, CAS and WE strobes and selects the row or the column onto the multiplexed address bus. It signals completion with a single-cycle done pulse. Every phase length is looked up from a small code, not counted directly. The codes cover RAS precharge, RAS-to-CAS delay, CAS low time and RAS hold after CAS. The RAS-to-CAS table also depends on a trace-delay mode bit.

The controller may have just written to the graphics slave port, which shares the memory data bus. In that case a DRAM read waits a few extra clocks before its precharge starts. A 2-bit turnaround code sets that wait. The sequencer notes each port write on a strobe input. Only a read that directly follows the port write pays the wait.

All timing codes are captured when the request is accepted. A sequence in flight therefore keeps its timing even if software edits the codes. Requests are taken only while the block is idle.

Top module: `edoseq_top`

## Requirements
- R1: After reset, rasN, casN and weN are 1, done is 0 and addrSel is 0 (row).
- R2: After a request is accepted, rasN stays high for the RAS precharge time before falling. The rasPreCode lookup is 000→12, 001→13, 010→21, 011→17, 100→19, 101→14, 110→15 and 111→16 clocks.
- R3: rasN low with casN high lasts the RAS-to-CAS time, and memAddr carries the row (addrSel=0) throughout. With traceDly=1 the rcdCode lookup is 000→13, 001→17, 010→20, 011→11, 100→19, 101→14 and 110→15. With traceDly=0, codes 010, 011 and 100 give 19, 12 and 18 instead.
- R4: casN is low for the CAS width with casWidthCode 001→4, 010→5 and 011→6 clocks. During that time rasN is low and memAddr carries the column (addrSel=1).
- R5: After casN rises, rasN stays low for rasHoldCode+4 clocks (codes 000 to 110).
- R6: When the hold ends, done is 1 for exactly one cycle with rasN and casN high, and the block returns to idle.
- R7: On a write, weN is low from the fall of rasN until casN rises, and high at all other times. On a read, weN stays high throughout.
- R8: A pulse on portWrite arms a turnaround wait. A read accepted while armed keeps rasN high for an extra 4−turnCode clocks (11→1, 10→2, 01→3, 00→4) before the precharge. Any accepted request clears the armed state, and a write never waits.
- R9: reqValid is ignored while a sequence is in progress. No second sequence starts after done unless a new request arrives in idle.
- R10: Reserved codes fall back to the longest legal value: rcdCode 111→20 clocks, casWidthCode 000 or 100–111→6 clocks, rasHoldCode 111→10 clocks.
- R11: Timing codes and the request are sampled only at acceptance. Changing them during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | RowW | Row address |
| reqCol | input | ColW | Column address |
| rcdCode | input | 3 | RAS-to-CAS delay code |
| traceDly | input | 1 | Trace-delay mode for the RAS-to-CAS table |
| casWidthCode | input | 3 | CAS low-time code |
| rasPreCode | input | 3 | RAS precharge code |
| rasHoldCode | input | 3 | RAS hold after CAS code |
| turnCode | input | 2 | Port-write-to-read turnaround code |
| portWrite | input | 1 | Strobe: a graphics port write just took place |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addrSel | output | 1 | Address mux select, 0 row, 1 column |
| memAddr | output | max(RowW,ColW) | Multiplexed DRAM address |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase state or a wrong counter load shows up as a phase length that is off by one or more clocks, measured at the strobe edges of the same access. It is visible no later than that access's done pulse. A stale or wrongly armed turnaround flag shows up as a precharge interval longer or shorter than expected on the next read. A WE or address-select decode error shows on the very cycle the strobe is driven.

// File: rtl/edoseq_pkg.sv
`timescale 1ns/1ps
package edoseq_pkg;

  localparam int CntW = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_PRECH, PH_RCD, PH_CAS, PH_HOLD, PH_DONE
  } phase_t;

  typedef struct packed {
    logic [2:0] rcd;
    logic       traceDly;
    logic [2:0] casW;
    logic [2:0] rasPre;
    logic [2:0] rasHold;
    logic [1:0] turn;
  } timing_t;

  typedef struct packed {
    logic   accept;
    logic   load;
    phase_t loadPhase;
    logic   dec;
    logic   selCol;
  } strobe_t;

  function automatic logic [CntW-1:0] rcdClocks(input logic [2:0] code, input logic td);
    logic [CntW-1:0] r;
    case (code)
      3'd0: r = CntW'(13);
      3'd1: r = CntW'(17);
      3'd2: r = td ? CntW'(20) : CntW'(19);
      3'd3: r = td ? CntW'(11) : CntW'(12);
      3'd4: r = td ? CntW'(19) : CntW'(18);
      3'd5: r = CntW'(14);
      3'd6: r = CntW'(15);
      default: r = CntW'(20);
    endcase
    return r;
  endfunction

  function automatic logic [CntW-1:0] casClocks(input logic [2:0] code);
    logic [CntW-1:0] r;
    case (code)
      3'd1: r = CntW'(4);
      3'd2: r = CntW'(5);
      default: r = CntW'(6);
    endcase
    return r;
  endfunction

  function automatic logic [CntW-1:0] rasPreClocks(input logic [2:0] code);
    logic [CntW-1:0] r;
    case (code)
      3'd0: r = CntW'(12);
      3'd1: r = CntW'(13);
      3'd2: r = CntW'(21);
      3'd3: r = CntW'(17);
      3'd4: r = CntW'(19);
      3'd5: r = CntW'(14);
      3'd6: r = CntW'(15);
      default: r = CntW'(16);
    endcase
    return r;
  endfunction

  function automatic logic [CntW-1:0] holdClocks(input logic [2:0] code);
    return (code == 3'd7) ? CntW'(10) : CntW'(code) + CntW'(4);
  endfunction

  function automatic logic [CntW-1:0] turnClocks(input logic [1:0] code);
    return CntW'(4) - CntW'(code);
  endfunction

  function automatic logic [CntW-1:0] phaseLen(input phase_t ph, input timing_t t);
    logic [CntW-1:0] r;
    case (ph)
      PH_TURN:  r = turnClocks(t.turn);
      PH_PRECH: r = rasPreClocks(t.rasPre);
      PH_RCD:   r = rcdClocks(t.rcd, t.traceDly);
      PH_CAS:   r = casClocks(t.casW);
      PH_HOLD:  r = holdClocks(t.rasHold);
      default:  r = CntW'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/edoseq_dp.sv
`timescale 1ns/1ps
module edoseq_dp
  import edoseq_pkg::*;
#(
  parameter int RowW  = 11,
  parameter int ColW  = 11,
  parameter int AddrW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic             reqWrite,
  input  logic [RowW-1:0]  reqRow,
  input  logic [ColW-1:0]  reqCol,
  input  timing_t          liveCodes,
  input  logic             portWrite,
  output logic             cntZero,
  output logic             turnNeeded,
  output logic             wrLatched,
  output logic [AddrW-1:0] memAddr
);

  logic [RowW-1:0] rowQ;
  logic [ColW-1:0] colQ;
  logic            wrQ;
  timing_t         codesQ;
  logic            armedQ;
  logic [CntW-1:0] cntQ;
  timing_t         lenSrc;
  logic [CntW-1:0] lenNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      wrQ    <= 1'b0;
      codesQ <= '0;
    end else if (st.accept) begin
      rowQ   <= reqRow;
      colQ   <= reqCol;
      wrQ    <= reqWrite;
      codesQ <= liveCodes;
    end
  end

  // a port write arms the turnaround; any accepted request consumes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armedQ <= 1'b0;
    else if (portWrite) armedQ <= 1'b1;
    else if (st.accept) armedQ <= 1'b0;
  end

  assign turnNeeded = armedQ && !reqWrite;

  assign lenSrc = st.accept ? liveCodes : codesQ;
  assign lenNow = phaseLen(st.loadPhase, lenSrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntQ <= '0;
    else if (st.load) cntQ <= lenNow - CntW'(1);
    else if (st.dec)  cntQ <= cntQ - CntW'(1);
  end

  assign cntZero   = (cntQ == '0);
  assign wrLatched = wrQ;
  assign memAddr   = st.selCol ? AddrW'(colQ) : AddrW'(rowQ);

endmodule

// File: rtl/edoseq_ctrl.sv
`timescale 1ns/1ps
module edoseq_ctrl
  import edoseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cntZero,
  input  logic    turnNeeded,
  input  logic    wrLatched,
  output strobe_t st,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    addrSel,
  output logic    done
);

  phase_t stateQ, stateD;

  function automatic phase_t succ(input phase_t p);
    phase_t r;
    case (p)
      PH_TURN:  r = PH_PRECH;
      PH_PRECH: r = PH_RCD;
      PH_RCD:   r = PH_CAS;
      PH_CAS:   r = PH_HOLD;
      PH_HOLD:  r = PH_DONE;
      default:  r = PH_IDLE;
    endcase
    return r;
  endfunction

  always_comb begin
    stateD = stateQ;
    st     = '0;
    st.loadPhase = PH_IDLE;
    case (stateQ)
      PH_IDLE: begin
        if (reqValid) begin
          st.accept    = 1'b1;
          st.load      = 1'b1;
          stateD       = turnNeeded ? PH_TURN : PH_PRECH;
          st.loadPhase = stateD;
        end
      end
      PH_DONE: stateD = PH_IDLE;
      default: begin
        if (cntZero) begin
          stateD = succ(stateQ);
          if (stateD != PH_DONE) begin
            st.load      = 1'b1;
            st.loadPhase = stateD;
          end
        end else begin
          st.dec = 1'b1;
        end
      end
    endcase
    st.selCol = (stateQ == PH_CAS) || (stateQ == PH_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PH_IDLE;
    else       stateQ <= stateD;
  end

  assign rasN    = !((stateQ == PH_RCD) || (stateQ == PH_CAS) || (stateQ == PH_HOLD));
  assign casN    = !(stateQ == PH_CAS);
  assign weN     = !(wrLatched && ((stateQ == PH_RCD) || (stateQ == PH_CAS)));
  assign addrSel = st.selCol;
  assign done    = (stateQ == PH_DONE);

endmodule

// File: rtl/edoseq_top.sv
`timescale 1ns/1ps
module edoseq_top
  import edoseq_pkg::*;
#(
  parameter int RowW = 11,
  parameter int ColW = 11,
  localparam int AddrW = (RowW > ColW) ? RowW : ColW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [RowW-1:0]  reqRow,
  input  logic [ColW-1:0]  reqCol,
  input  logic [2:0]       rcdCode,
  input  logic             traceDly,
  input  logic [2:0]       casWidthCode,
  input  logic [2:0]       rasPreCode,
  input  logic [2:0]       rasHoldCode,
  input  logic [1:0]       turnCode,
  input  logic             portWrite,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             addrSel,
  output logic [AddrW-1:0] memAddr,
  output logic             done
);

  strobe_t st;
  timing_t liveCodes;
  logic    cntZero, turnNeeded, wrLatched;

  assign liveCodes = '{rcd: rcdCode, traceDly: traceDly, casW: casWidthCode,
                       rasPre: rasPreCode, rasHold: rasHoldCode, turn: turnCode};

  edoseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cntZero(cntZero),
    .turnNeeded(turnNeeded), .wrLatched(wrLatched), .st(st),
    .rasN(rasN), .casN(casN), .weN(weN), .addrSel(addrSel), .done(done)
  );

  edoseq_dp #(.RowW(RowW), .ColW(ColW), .AddrW(AddrW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqWrite(reqWrite), .reqRow(reqRow),
    .reqCol(reqCol), .liveCodes(liveCodes), .portWrite(portWrite),
    .cntZero(cntZero), .turnNeeded(turnNeeded), .wrLatched(wrLatched),
    .memAddr(memAddr)
  );

endmodule

// File: rtl/edoseq_chk.sv
`timescale 1ns/1ps
module edoseq_chk (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic addrSel,
  input logic done
);

  // R4
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R4
  cas_on_column_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> addrSel);

  // R3
  ras_fall_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!addrSel && casN));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_idle_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rasN && casN && weN));

  // R7
  we_within_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !rasN);

  // R7
  we_steady_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && $past(!casN)) |-> $stable(weN));

endmodule

bind edoseq_top edoseq_chk u_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
  .addrSel(addrSel), .done(done)
);

// File: tb/tb_edoseq_top.sv
`timescale 1ns/1ps
module tb_edoseq_top;

  localparam int RowW = 11;
  localparam int ColW = 11;
  localparam int NVec = 12;

  // {portWrBefore, write, traceDly, rcd, casW, rasPre, rasHold, turn}
  localparam logic [16:0] VEC [NVec] = '{
    17'b0_0_1_000_001_000_000_00,
    17'b0_1_1_001_010_001_001_01,
    17'b0_0_0_010_011_010_010_10,
    17'b0_1_0_011_001_011_011_11,
    17'b0_0_1_100_010_100_100_00,
    17'b0_1_0_100_011_101_101_00,
    17'b1_0_1_101_001_110_110_11,
    17'b1_0_0_110_010_111_000_00,
    17'b1_1_1_010_011_000_001_01,
    17'b0_0_1_011_001_001_010_10,
    17'b0_0_1_111_000_010_111_00,
    17'b1_0_0_111_101_011_011_01
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, traceDly = 1'b0, portWrite = 1'b0;
  logic [RowW-1:0] reqRow = '0;
  logic [ColW-1:0] reqCol = '0;
  logic [2:0] rcdCode = '0, casWidthCode = '0, rasPreCode = '0, rasHoldCode = '0;
  logic [1:0] turnCode = '0;
  logic rasN, casN, weN, addrSel, done;
  logic [10:0] memAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  edoseq_top #(.RowW(RowW), .ColW(ColW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .rcdCode(rcdCode), .traceDly(traceDly),
    .casWidthCode(casWidthCode), .rasPreCode(rasPreCode),
    .rasHoldCode(rasHoldCode), .turnCode(turnCode), .portWrite(portWrite),
    .rasN(rasN), .casN(casN), .weN(weN), .addrSel(addrSel),
    .memAddr(memAddr), .done(done)
  );

  function automatic int expRcd(int code, bit td);
    int hi[8] = '{13, 17, 20, 11, 19, 14, 15, 20};
    int lo[8] = '{13, 17, 19, 12, 18, 14, 15, 20};
    return td ? hi[code] : lo[code];
  endfunction
  function automatic int expCas(int code);
    return (code >= 1 && code <= 3) ? code + 3 : 6;
  endfunction
  function automatic int expRp(int code);
    int t[8] = '{12, 13, 21, 17, 19, 14, 15, 16};
    return t[code];
  endfunction
  function automatic int expRsc(int code);
    return (code == 7) ? 10 : code + 4;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runAccess(logic [16:0] v, logic [RowW-1:0] row, logic [ColW-1:0] col,
                           bit armed);
    bit pw, wr;
    int n, expPre;
    bit addrOk, weOk, rasOk;
    pw = v[16]; wr = v[15];
    @(negedge clk);
    if (pw) begin
      portWrite = 1'b1;
      @(negedge clk);
      portWrite = 1'b0;
    end
    reqWrite = wr; traceDly = v[14]; rcdCode = v[13:11]; casWidthCode = v[10:8];
    rasPreCode = v[7:5]; rasHoldCode = v[4:2]; turnCode = v[1:0];
    reqRow = row; reqCol = col; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    expPre = expRp(v[7:5]) + (((pw || armed) && !wr) ? 4 - int'(v[1:0]) : 0);
    n = 0;
    while (rasN === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk(n == expPre, "R2/R8", "precharge+turnaround clocks", n, expPre);
    n = 0; addrOk = 1; weOk = 1;
    while (rasN === 1'b0 && casN === 1'b1 && n < 100) begin
      if (memAddr !== 11'(row) || addrSel !== 1'b0) addrOk = 0;
      if (weN !== !wr) weOk = 0;
      n++; @(negedge clk);
    end
    chk(n == expRcd(v[13:11], v[14]), "R3/R10", "RAS-to-CAS clocks", n, expRcd(v[13:11], v[14]));
    chk(addrOk, "R3", "row on address bus", addrOk, 1);
    n = 0; rasOk = 1;
    while (casN === 1'b0 && n < 100) begin
      if (memAddr !== 11'(col) || addrSel !== 1'b1) addrOk = 0;
      if (weN !== !wr) weOk = 0;
      if (rasN !== 1'b0) rasOk = 0;
      n++; @(negedge clk);
    end
    chk(n == expCas(v[10:8]), "R4/R10", "CAS low clocks", n, expCas(v[10:8]));
    chk(addrOk && rasOk, "R4", "column with RAS low", addrOk && rasOk, 1);
    n = 0;
    while (rasN === 1'b0 && casN === 1'b1 && n < 100) begin
      if (weN !== 1'b1) weOk = 0;
      n++; @(negedge clk);
    end
    chk(n == expRsc(v[4:2]), "R5/R10", "RAS hold clocks", n, expRsc(v[4:2]));
    chk(weOk, "R7", "WE pattern", weOk, 1);
    chk(done === 1'b1 && rasN === 1'b1 && casN === 1'b1, "R6", "done with strobes high",
        done, 1);
    @(negedge clk);
    chk(done === 1'b0 && rasN === 1'b1, "R6", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rasN === 1'b1 && casN === 1'b1 && weN === 1'b1 && done === 1'b0 && addrSel === 1'b0,
        "R1", "reset strobes", {rasN, casN, weN, done, addrSel}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    chk(rasN === 1'b1 && done === 1'b0, "R1", "idle after reset", rasN, 1);

    for (int i = 0; i < NVec; i++)
      runAccess(VEC[i], 11'(i * 37 + 5), 11'(~(i * 37 + 5)), 1'b0);

    // R9 and R11: request and code changes during a sequence are ignored
    fork
      runAccess(17'b0_1_1_001_010_001_001_00, 11'h155, 11'h2AA, 1'b0);
      begin
        repeat (6) @(negedge clk);
        reqValid = 1'b1; reqRow = 11'h0F0; rcdCode = 3'd2; rasPreCode = 3'd2;
        casWidthCode = 3'd3; rasHoldCode = 3'd6;
        repeat (20) @(negedge clk);
        reqValid = 1'b0;
      end
    join
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 40; k++) begin
        if (rasN !== 1'b1 || done !== 1'b0) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R9", "no sequence after ignored request", quiet, 1);
    end

    // R8: armed read pays turnaround, then flag is consumed
    runAccess(17'b1_0_1_000_001_000_000_10, 11'h011, 11'h022, 1'b0);
    runAccess(17'b0_0_1_000_001_000_000_10, 11'h033, 11'h044, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule